// File: doc/BRIEF.md
# Video Pixel Bus Formatter

This block sits at the output of a video decoder. Each pixel clock it accepts one full-resolution pixel as three 8-bit channels, along with the line and frame qualifiers: blanking, horizontal and vertical sync, data-valid, VBI-valid and field. It packs the pixel onto a 16-bit parallel bus in one of three layouts, chosen by a format input. The layouts are 4:2:2 YCbCr with luma and chroma on one bus, RGB 5-6-5, and RGB 5-5-5. Colour conversion and gamma have already been applied upstream. The block only chooses bits, replaces pixels with a blanking level where needed, and registers the result.

In the YCbCr layout the chroma byte alternates between Cb and Cr. The phase moves forward on each data-valid cycle. It goes back to Cb on the first cycle of active video, which is the first cycle with blanking low after a blanked cycle. During blanking the bus shows a fixed black level. The exception is when VBI data is flagged valid: the incoming samples then pass through so that ancillary data reaches the bus. All outputs, qualifiers included, leave one register stage, so they stay aligned with one another.

The channel inputs carry Y/Cb/Cr in YCbCr format and R/G/B in the RGB formats.

Top module: `vid_bus_packer`

## Requirements
- R1: Every output is registered. The values on the bus and on the six flag outputs appear one clock after the inputs they come from, and each flag output equals its input flag from the previous cycle.
- R2: With fmt_sel = 0 (YCbCr 4:2:2) and blanking low, px_bus[15:8] carries the luma input `pix_y_r`.
- R3: With fmt_sel = 0, px_bus[7:0] carries Cb (`pix_cb_g`) or Cr (`pix_cr_b`) as set by a chroma phase. A cycle with dvalid high advances the phase. A cycle with dvalid low leaves it unchanged.
- R4: The chroma phase returns to Cb on a cycle where blank is low and the previous cycle's blank was high. That cycle outputs Cb.
- R5: With fmt_sel = 1 or 3 (RGB 5-6-5), px_bus = {R[7:3], G[7:2], B[7:3]}.
- R6: With fmt_sel = 2 (RGB 5-5-5), px_bus = {1'b0, R[7:3], G[7:3], B[7:3]}. Bit 15 is always zero.
- R7: With blank high, vbivalid low and fmt_sel = 0, px_bus is 16'h1080 (Y=16, chroma=128).
- R8: With blank high, vbivalid low and an RGB format, px_bus is 16'h0000.
- R9: With blank high and vbivalid high, the bus takes the packing of the selected format, unaltered. In YCbCr format the chroma phase is used.
- R10: A synchronous active-high reset sets every output to zero and the chroma phase to Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | 0 YCbCr 4:2:2, 1/3 RGB 5-6-5, 2 RGB 5-5-5 |
| pix_y_r | input | 8 | Luma or red channel |
| pix_cb_g | input | 8 | Cb or green channel |
| pix_cr_b | input | 8 | Cr or blue channel |
| in_blank | input | 1 | Blanking qualifier |
| in_hsync | input | 1 | Horizontal sync |
| in_vsync | input | 1 | Vertical sync |
| in_dvalid | input | 1 | Pixel valid strobe |
| in_vbivalid | input | 1 | VBI data valid |
| in_field | input | 1 | Field indicator |
| px_bus | output | 16 | Packed pixel bus |
| o_blank | output | 1 | Registered blanking |
| o_hsync | output | 1 | Registered horizontal sync |
| o_vsync | output | 1 | Registered vertical sync |
| o_dvalid | output | 1 | Registered pixel valid |
| o_vbivalid | output | 1 | Registered VBI valid |
| o_field | output | 1 | Registered field |

## Verification
Every result, whether packing, blank substitution, chroma choice or flag copy, is due exactly one rising edge after the inputs that cause it. Reset clears the outputs at the edge where it is sampled. The bench drives inputs on the falling edge. On the next falling edge it compares the outputs against the value its reference model predicted from the previous inputs. The model tracks the chroma phase from data-valid and from the falling edge of blanking, so line restarts are checked on the cycle they take effect.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
    localparam int CH_W  = 8;
    localparam int BUS_W = 16;

    typedef enum logic [1:0] {
        FMT_YCC     = 2'd0,
        FMT_RGB16   = 2'd1,
        FMT_RGB15   = 2'd2,
        FMT_RGB16_B = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic             blank;
        logic             hsync;
        logic             vsync;
        logic             dvalid;
        logic             vbivalid;
        logic             field;
    } out_s;

    typedef struct packed {
        logic prev_blank;
        logic use_cr;
    } phase_s;
endpackage

// File: rtl/vpk_chroma_phase.sv
module vpk_chroma_phase (
    input  logic clk,
    input  logic rst,
    input  logic blank,
    input  logic dvalid,
    output logic use_cr
);
    import vpk_pkg::*;

    phase_s st_d, st_q;
    logic   restart;

    always_comb begin
        restart       = st_q.prev_blank && !blank;
        use_cr        = restart ? 1'b0 : st_q.use_cr;
        st_d          = st_q;
        st_d.prev_blank = blank;
        st_d.use_cr   = dvalid ? ~use_cr : use_cr;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/vpk_ycc_pack.sv
module vpk_ycc_pack #(
    parameter int CH_W  = 8,
    parameter int BUS_W = 16
) (
    input  logic [CH_W-1:0]  y,
    input  logic [CH_W-1:0]  cb,
    input  logic [CH_W-1:0]  cr,
    input  logic             use_cr,
    output logic [BUS_W-1:0] bus
);
    localparam int PAD = BUS_W - 2 * CH_W;

    logic [CH_W-1:0] chroma;
    assign chroma = use_cr ? cr : cb;

    generate
        if (PAD > 0) begin : g_pad
            assign bus = {{PAD{1'b0}}, y, chroma};
        end else begin : g_nopad
            assign bus = {y, chroma};
        end
    endgenerate
endmodule

// File: rtl/vpk_rgb_pack.sv
module vpk_rgb_pack #(
    parameter int CH_W   = 8,
    parameter int BUS_W  = 16,
    parameter int G_BITS = 6
) (
    input  logic [CH_W-1:0]  r,
    input  logic [CH_W-1:0]  g,
    input  logic [CH_W-1:0]  b,
    output logic [BUS_W-1:0] bus
);
    localparam int RB_BITS = 5;
    localparam int PAD     = BUS_W - 2 * RB_BITS - G_BITS;

    logic [RB_BITS-1:0] r_t, b_t;
    logic [G_BITS-1:0]  g_t;

    assign r_t = r[CH_W-1 -: RB_BITS];
    assign g_t = g[CH_W-1 -: G_BITS];
    assign b_t = b[CH_W-1 -: RB_BITS];

    generate
        if (PAD > 0) begin : g_pad
            assign bus = {{PAD{1'b0}}, r_t, g_t, b_t};
        end else begin : g_nopad
            assign bus = {r_t, g_t, b_t};
        end
    endgenerate
endmodule

// File: rtl/vid_bus_packer.sv
module vid_bus_packer #(
    parameter int          CH_W    = vpk_pkg::CH_W,
    parameter int          BUS_W   = vpk_pkg::BUS_W,
    parameter logic [7:0]  Y_BLACK = 8'd16,
    parameter logic [7:0]  C_BLACK = 8'd128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       fmt_sel,
    input  logic [CH_W-1:0]  pix_y_r,
    input  logic [CH_W-1:0]  pix_cb_g,
    input  logic [CH_W-1:0]  pix_cr_b,
    input  logic             in_blank,
    input  logic             in_hsync,
    input  logic             in_vsync,
    input  logic             in_dvalid,
    input  logic             in_vbivalid,
    input  logic             in_field,
    output logic [BUS_W-1:0] px_bus,
    output logic             o_blank,
    output logic             o_hsync,
    output logic             o_vsync,
    output logic             o_dvalid,
    output logic             o_vbivalid,
    output logic             o_field
);
    import vpk_pkg::*;

    localparam logic [BUS_W-1:0] YCC_BLACK = BUS_W'({Y_BLACK, C_BLACK});

    out_s             out_d, out_q;
    logic             use_cr;
    logic [BUS_W-1:0] ycc_bus, rgb16_bus, rgb15_bus;
    logic             force_black;
    fmt_e             fmt;

    vpk_chroma_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .blank  (in_blank),
        .dvalid (in_dvalid),
        .use_cr (use_cr)
    );

    vpk_ycc_pack #(.CH_W(CH_W), .BUS_W(BUS_W)) u_ycc (
        .y      (pix_y_r),
        .cb     (pix_cb_g),
        .cr     (pix_cr_b),
        .use_cr (use_cr),
        .bus    (ycc_bus)
    );

    vpk_rgb_pack #(.CH_W(CH_W), .BUS_W(BUS_W), .G_BITS(6)) u_rgb16 (
        .r   (pix_y_r),
        .g   (pix_cb_g),
        .b   (pix_cr_b),
        .bus (rgb16_bus)
    );

    vpk_rgb_pack #(.CH_W(CH_W), .BUS_W(BUS_W), .G_BITS(5)) u_rgb15 (
        .r   (pix_y_r),
        .g   (pix_cb_g),
        .b   (pix_cr_b),
        .bus (rgb15_bus)
    );

    always_comb begin
        fmt         = fmt_e'(fmt_sel);
        force_black = in_blank && !in_vbivalid;
        out_d       = out_q;
        unique case (fmt)
            FMT_YCC:   out_d.bus = force_black ? YCC_BLACK : ycc_bus;
            FMT_RGB15: out_d.bus = force_black ? '0 : rgb15_bus;
            default:   out_d.bus = force_black ? '0 : rgb16_bus;
        endcase
        out_d.blank    = in_blank;
        out_d.hsync    = in_hsync;
        out_d.vsync    = in_vsync;
        out_d.dvalid   = in_dvalid;
        out_d.vbivalid = in_vbivalid;
        out_d.field    = in_field;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign px_bus     = out_q.bus;
    assign o_blank    = out_q.blank;
    assign o_hsync    = out_q.hsync;
    assign o_vsync    = out_q.vsync;
    assign o_dvalid   = out_q.dvalid;
    assign o_vbivalid = out_q.vbivalid;
    assign o_field    = out_q.field;
endmodule

// File: rtl/vpk_checks.sv
module vpk_checks (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  fmt_sel,
    input logic [7:0]  pix_y_r,
    input logic [7:0]  pix_cb_g,
    input logic        in_blank,
    input logic        in_hsync,
    input logic        in_dvalid,
    input logic        in_vbivalid,
    input logic [15:0] px_bus,
    input logic        o_blank,
    input logic        o_hsync,
    input logic        o_vsync,
    input logic        o_dvalid,
    input logic        o_vbivalid,
    input logic        o_field
);
    p_flag_delay_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (o_hsync == $past(in_hsync) && o_dvalid == $past(in_dvalid)));

    p_luma_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'd0 && !in_blank) |=> px_bus[15:8] == $past(pix_y_r));

    p_line_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'd0 && o_blank && !in_blank) |=> px_bus[7:0] == $past(pix_cb_g));

    p_bit15_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'd2) |=> !px_bus[15]);

    p_ycc_black_r7: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'd0 && in_blank && !in_vbivalid) |=> px_bus == 16'h1080);

    p_rgb_black_r8: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel != 2'd0 && in_blank && !in_vbivalid) |=> px_bus == 16'h0000);

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (px_bus == 16'h0 && !o_blank && !o_hsync && !o_vsync
                 && !o_dvalid && !o_vbivalid && !o_field));
endmodule

bind vid_bus_packer vpk_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .fmt_sel     (fmt_sel),
    .pix_y_r     (pix_y_r),
    .pix_cb_g    (pix_cb_g),
    .in_blank    (in_blank),
    .in_hsync    (in_hsync),
    .in_dvalid   (in_dvalid),
    .in_vbivalid (in_vbivalid),
    .px_bus      (px_bus),
    .o_blank     (o_blank),
    .o_hsync     (o_hsync),
    .o_vsync     (o_vsync),
    .o_dvalid    (o_dvalid),
    .o_vbivalid  (o_vbivalid),
    .o_field     (o_field)
);

// File: tb/sim_vid_bus_packer.sv
`timescale 1ns/1ps
module sim_vid_bus_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'd0;
    logic [7:0]  pix_y_r = 8'd0, pix_cb_g = 8'd0, pix_cr_b = 8'd0;
    logic        in_blank = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
    logic        in_dvalid = 1'b0, in_vbivalid = 1'b0, in_field = 1'b0;
    logic [15:0] px_bus;
    logic        o_blank, o_hsync, o_vsync, o_dvalid, o_vbivalid, o_field;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // reference model state
    bit          m_prev_blank = 1'b0;
    bit          m_cr = 1'b0;
    logic [15:0] e_bus;
    logic [5:0]  e_flags;
    string       e_tag;
    string       e_ctag;
    bit          e_ycc_live;

    always #5 clk = ~clk;

    vid_bus_packer u0 (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel),
        .pix_y_r(pix_y_r), .pix_cb_g(pix_cb_g), .pix_cr_b(pix_cr_b),
        .in_blank(in_blank), .in_hsync(in_hsync), .in_vsync(in_vsync),
        .in_dvalid(in_dvalid), .in_vbivalid(in_vbivalid), .in_field(in_field),
        .px_bus(px_bus), .o_blank(o_blank), .o_hsync(o_hsync), .o_vsync(o_vsync),
        .o_dvalid(o_dvalid), .o_vbivalid(o_vbivalid), .o_field(o_field)
    );

    function automatic logic [15:0] pack(input logic [1:0] f, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] c,
                                         input bit cr);
        case (f)
            2'd0:    pack = {a, cr ? c : b};
            2'd2:    pack = {1'b0, a[7:3], b[7:3], c[7:3]};
            default: pack = {a[7:3], b[7:2], c[7:3]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // compute expected outputs for inputs currently driven, then update model
    task automatic predict();
        bit restart;
        bit use_cr;
        restart = m_prev_blank && !in_blank;
        use_cr  = restart ? 1'b0 : m_cr;
        e_flags = {in_blank, in_hsync, in_vsync, in_dvalid, in_vbivalid, in_field};
        e_ycc_live = 1'b0;
        e_ctag = "";
        if (rst) begin
            e_bus = 16'h0; e_flags = '0; e_tag = "R10";
            m_prev_blank = 1'b0; m_cr = 1'b0;
            return;
        end
        if (in_blank && !in_vbivalid) begin
            e_bus = (fmt_sel == 2'd0) ? 16'h1080 : 16'h0000;
            e_tag = (fmt_sel == 2'd0) ? "R7" : "R8";
        end else begin
            e_bus = pack(fmt_sel, pix_y_r, pix_cb_g, pix_cr_b, use_cr);
            if (in_blank) e_tag = "R9";
            else if (fmt_sel == 2'd0) begin
                e_tag = "R2"; e_ycc_live = 1'b1;
                e_ctag = restart ? "R4" : "R3";
            end
            else if (fmt_sel == 2'd2) e_tag = "R6";
            else e_tag = "R5";
        end
        m_prev_blank = in_blank;
        m_cr = in_dvalid ? ~use_cr : use_cr;
    endtask

    task automatic verify();
        if (e_ycc_live) begin
            check(e_tag, {8'h0, px_bus[15:8]}, {8'h0, e_bus[15:8]});
            check(e_ctag, {8'h0, px_bus[7:0]}, {8'h0, e_bus[7:0]});
        end else begin
            check(e_tag, px_bus, e_bus);
        end
        check(e_tag == "R10" ? "R10" : "R1",
              {10'h0, o_blank, o_hsync, o_vsync, o_dvalid, o_vbivalid, o_field},
              {10'h0, e_flags});
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        verify();
    endtask

    task automatic drive(input logic [1:0] f, input logic bl, input logic dv,
                         input logic vb, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c);
        fmt_sel = f; in_blank = bl; in_dvalid = dv; in_vbivalid = vb;
        pix_y_r = a; pix_cb_g = b; pix_cr_b = c;
        in_hsync = $urandom_range(0, 1); in_vsync = $urandom_range(0, 1);
        in_field = $urandom_range(0, 1);
        step();
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int run;
        bit bl;
        void'($urandom(32'd4711));
        // R10: reset with busy inputs
        @(negedge clk);
        rst = 1'b1;
        drive(2'd0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55, 8'h33);
        drive(2'd1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF);
        rst = 1'b0;
        // directed YCbCr line: blank, then active with alternation and a stall
        drive(2'd0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 8'h33);   // R7
        drive(2'd0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h55, 8'h66);   // R9 vbi pass
        drive(2'd0, 1'b0, 1'b1, 1'b0, 8'h80, 8'hC1, 8'hD1);   // R4 restart Cb
        drive(2'd0, 1'b0, 1'b1, 1'b0, 8'h81, 8'hC2, 8'hD2);   // R3 Cr
        drive(2'd0, 1'b0, 1'b0, 1'b0, 8'h82, 8'hC3, 8'hD3);   // R3 hold (Cb)
        drive(2'd0, 1'b0, 1'b1, 1'b0, 8'h83, 8'hC4, 8'hD4);   // R3 Cb
        drive(2'd0, 1'b0, 1'b1, 1'b0, 8'h84, 8'hC5, 8'hD5);   // R3 Cr
        // RGB corners
        drive(2'd1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF);   // R5
        drive(2'd3, 1'b0, 1'b1, 1'b0, 8'h07, 8'hFC, 8'h08);   // R5 alt code
        drive(2'd2, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF);   // R6 bit15 zero
        drive(2'd2, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF);   // R8
        drive(2'd1, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F, 8'hA5);   // R9
        // random lines
        run = 0; bl = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (run == 0) begin
                bl = ~bl;
                run = $urandom_range(2, 24);
                if (($urandom_range(0, 3) == 0)) fmt_sel = 2'($urandom_range(0, 3));
            end
            run--;
            if (i == 2000) rst = 1'b1;
            if (i == 2002) rst = 1'b0;
            drive(fmt_sel, bl, ($urandom_range(0, 3) != 0),
                  bl ? 1'($urandom_range(0, 1)) : 1'b0,
                  8'($urandom), 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule